// File: doc/BRIEF.md
# Register-Mapped Pin Controller with Per-Pin Interrupt Detection

This block controls 32 general-purpose pins through a flat 32-bit register bus. The bus has an address, a write strobe, write data and combinational read data. Each pin has its own 8-bit configuration word. That word enables the pin's output value and output buffer, gates its input sample and selects an interrupt trigger. Incoming pin levels pass through a two-stage synchronizer. The synchronized value, together with its copy from one cycle earlier, feeds per-pin level and edge detectors.

Detected events set bits in a sticky pending register. Software clears that register by writing ones. A single interrupt line reports whether any bit is still pending. Software can rewrite the output word directly, or it can change individual bits through dedicated set and clear registers with no read-modify-write. To configure many pins in one write, software can use a broadcast word that reaches every pin, or four group words that each reach eight neighbouring pins.

Top module: `pio_ctrl`

## Requirements
- R1: After reset, every configuration word, the output word and the pending register read zero, and `irq`, `pin_o` and `pin_oe` are all zero.
- R2: The configuration word of pin i sits at byte offset 4*i (0x00 to 0x7C). Its bit fields are:
  - bit 0 enables the output value, so that `pin_o[i]` is output bit i AND bit 0;
  - bit 1 enables the input sample;
  - bit 2 drives `pin_oe[i]`;
  - bit 3 enables the interrupt;
  - bits 7:5 hold the trigger code.
  Bit 4 and bits 31:8 always read zero.
- R3: A write to offset 0x8C loads its low byte into all 32 configuration words. A write to offset 0x90+4*g (g = 0..3) loads only the words of pins 8g to 8g+7.
- R4: The output word is written and read at 0x88. A write to 0xA4 ORs the data into the output word. A write to 0xA0 clears the bits that are one in the data.
- R5: Offset 0x84 reads the synchronized pin levels ANDed with each pin's bit 1. The read shows a pin change no more than three clock edges after the change. Writes to 0x84 have no effect.
- R6: Trigger code 000 detects a high level and 001 detects a low level. The event is present on every cycle that the level lasts.
- R7: Trigger code 010 detects a rising edge, 011 a falling edge and 100 either edge. Codes 101 to 111 never detect anything.
- R8: A pending bit is set only when the pin's bit 3 is one and its selected condition holds. An edge becomes pending no more than three clock edges after the pin changes.
- R9: A write to the pending register at 0x80 clears exactly the bits that are one in the data. A level event that is still present sets its bit again in the same cycle, so the bit stays set.
- R10: `irq` is one whenever any pending bit is set. `irq` falls only in the cycle after a write to 0x80.
- R11: A pending bit stays set after its cause disappears, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronized inside the block |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pin_i | input | 32 | Raw pin input levels |
| pin_o | output | 32 | Pin output values |
| pin_oe | output | 32 | Pin output-buffer enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The trigger detectors are exercised with single-pin rise, fall and level patterns on separate pins:
- a rise followed by a fall separates rising detection from falling detection;
- the both-edges code must catch each direction on its own;
- holding a level through a clear separates level triggers, which set their bit again, from edge triggers, which stay cleared.

A disabled pin and a reserved trigger code are toggled to show that they produce nothing. Two pins made pending together, then cleared one at a time, show that a clear touches only the bits written as one. On the data path, an asymmetric input word read back with one pin's input gated off separates per-pin gating from whole-word gating. Set and clear masks that include a pin whose output is disabled separate the stored output word from the driven pins.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned CFG_W = 8;

  typedef enum logic [2:0] {
    TRIG_LVL_HI = 3'd0,
    TRIG_LVL_LO = 3'd1,
    TRIG_RISE   = 3'd2,
    TRIG_FALL   = 3'd3,
    TRIG_BOTH   = 3'd4
  } trig_e;

  typedef struct packed {
    trig_e trig;
    logic  rsvd;
    logic  irq_en;
    logic  buf_en;
    logic  in_en;
    logic  out_en;
  } pin_cfg_t;

  localparam logic [7:0] OFS_STS = 8'h80;
  localparam logic [7:0] OFS_IN  = 8'h84;
  localparam logic [7:0] OFS_OUT = 8'h88;
  localparam logic [7:0] OFS_ALL = 8'h8C;
  localparam logic [7:0] OFS_GRP = 8'h90;
  localparam logic [7:0] OFS_CLR = 8'hA0;
  localparam logic [7:0] OFS_SET = 8'hA4;

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;
  logic [W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      hist_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign q      = sync_q;
  assign q_prev = hist_q;

endmodule

// File: rtl/pio_cfg_bank.sv
module pio_cfg_bank
  import pio_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [N_PINS-1:0]       wr_pin,
  input  logic                    wr_all,
  input  logic [N_PINS/8-1:0]     wr_grp,
  input  pin_cfg_t                wcfg,
  output pin_cfg_t [N_PINS-1:0]   cfg_q
);

  pin_cfg_t wcfg_clean;

  always_comb begin
    wcfg_clean      = wcfg;
    wcfg_clean.rsvd = 1'b0;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    logic     ce;
    pin_cfg_t cfg_d;

    always_comb begin
      ce    = wr_pin[i] | wr_all | wr_grp[i/8];
      cfg_d = wcfg_clean;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= '0;
      end else if (ce) begin
        cfg_q[i] <= cfg_d;
      end
    end
  end

endmodule

// File: rtl/pio_irq_detect.sv
module pio_irq_detect
  import pio_pkg::*;
#(
  parameter int unsigned N_PINS = 32
) (
  input  logic [N_PINS-1:0]     cur,
  input  logic [N_PINS-1:0]     prev,
  input  pin_cfg_t [N_PINS-1:0] cfg,
  output logic [N_PINS-1:0]     hit
);

  for (genvar i = 0; i < N_PINS; i++) begin : g_det
    logic cond;

    always_comb begin
      case (cfg[i].trig)
        TRIG_LVL_HI: cond = cur[i];
        TRIG_LVL_LO: cond = ~cur[i];
        TRIG_RISE:   cond = cur[i] & ~prev[i];
        TRIG_FALL:   cond = ~cur[i] & prev[i];
        TRIG_BOTH:   cond = cur[i] ^ prev[i];
        default:     cond = 1'b0;
      endcase
      hit[i] = cfg[i].irq_en & cond;
    end
  end

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_we,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq
);

  localparam int unsigned IDX_W  = $clog2(N_PINS);
  localparam int unsigned GRP_N  = N_PINS / 8;
  localparam int unsigned PIN_SZ = N_PINS * 4;

  localparam logic [AW-1:0] A_STS = AW'(OFS_STS);
  localparam logic [AW-1:0] A_IN  = AW'(OFS_IN);
  localparam logic [AW-1:0] A_OUT = AW'(OFS_OUT);
  localparam logic [AW-1:0] A_ALL = AW'(OFS_ALL);
  localparam logic [AW-1:0] A_CLR = AW'(OFS_CLR);
  localparam logic [AW-1:0] A_SET = AW'(OFS_SET);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // address decode
  logic                is_pin;
  logic [IDX_W-1:0]    pin_idx;
  logic [N_PINS-1:0]   wr_pin;
  logic [GRP_N-1:0]    wr_grp;
  logic                wr_all;
  logic                wr_sts;
  logic [N_PINS-1:0]   wmask;
  pin_cfg_t            wcfg;

  always_comb begin
    is_pin  = (32'(bus_addr) < PIN_SZ);
    pin_idx = bus_addr[2 +: IDX_W];
    wr_all  = bus_we && (bus_addr == A_ALL);
    wr_sts  = bus_we && (bus_addr == A_STS);
    wmask   = bus_wdata[N_PINS-1:0];
    wcfg    = pin_cfg_t'(bus_wdata[CFG_W-1:0]);
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_wr_pin
    assign wr_pin[i] = bus_we && is_pin && (pin_idx == IDX_W'(i));
  end

  for (genvar g = 0; g < GRP_N; g++) begin : g_wr_grp
    assign wr_grp[g] = bus_we && (bus_addr == AW'(32'(OFS_GRP) + 4 * g));
  end

  // configuration storage
  pin_cfg_t [N_PINS-1:0] cfg_q;

  pio_cfg_bank #(.N_PINS(N_PINS)) i_cfg (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_pin (wr_pin),
    .wr_all (wr_all),
    .wr_grp (wr_grp),
    .wcfg   (wcfg),
    .cfg_q  (cfg_q)
  );

  logic [N_PINS-1:0] out_en;
  logic [N_PINS-1:0] in_en;
  logic [N_PINS-1:0] buf_en;
  logic [N_PINS-1:0] irq_en;

  for (genvar i = 0; i < N_PINS; i++) begin : g_fields
    assign out_en[i] = cfg_q[i].out_en;
    assign in_en[i]  = cfg_q[i].in_en;
    assign buf_en[i] = cfg_q[i].buf_en;
    assign irq_en[i] = cfg_q[i].irq_en;
  end

  // input sampling and event detection
  logic [N_PINS-1:0] pin_sync;
  logic [N_PINS-1:0] pin_prev;
  logic [N_PINS-1:0] hit;
  logic [N_PINS-1:0] in_val;

  pio_sync #(.W(N_PINS)) i_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .d      (pin_i),
    .q      (pin_sync),
    .q_prev (pin_prev)
  );

  pio_irq_detect #(.N_PINS(N_PINS)) i_det (
    .cur  (pin_sync),
    .prev (pin_prev),
    .cfg  (cfg_q),
    .hit  (hit)
  );

  assign in_val = pin_sync & in_en;

  // output word
  logic [N_PINS-1:0] out_q;
  logic [N_PINS-1:0] out_d;
  logic              out_ce;

  always_comb begin
    out_ce = 1'b0;
    out_d  = out_q;
    if (bus_we) begin
      case (bus_addr)
        A_OUT: begin out_ce = 1'b1; out_d = wmask;          end
        A_SET: begin out_ce = 1'b1; out_d = out_q | wmask;  end
        A_CLR: begin out_ce = 1'b1; out_d = out_q & ~wmask; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_q <= '0;
    end else if (out_ce) begin
      out_q <= out_d;
    end
  end

  // pending register: clear-by-one, new events win over a clear
  logic [N_PINS-1:0] sts_q;
  logic [N_PINS-1:0] sts_d;
  logic [N_PINS-1:0] sts_clr;
  logic              sts_ce;

  always_comb begin
    sts_clr = wr_sts ? wmask : '0;
    sts_d   = (sts_q & ~sts_clr) | hit;
    sts_ce  = wr_sts | (|hit);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sts_q <= '0;
    end else if (sts_ce) begin
      sts_q <= sts_d;
    end
  end

  // read path
  always_comb begin
    bus_rdata = '0;
    if (is_pin) begin
      bus_rdata = DW'(cfg_q[pin_idx]);
    end else begin
      case (bus_addr)
        A_STS:   bus_rdata = DW'(sts_q);
        A_IN:    bus_rdata = DW'(in_val);
        A_OUT:   bus_rdata = DW'(out_q);
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_o  = out_q & out_en;
  assign pin_oe = buf_en;
  assign irq    = |sts_q;

endmodule

// File: rtl/pio_ctrl_chk.sv
module pio_ctrl_chk
  import pio_pkg::*;
#(
  parameter int unsigned N_PINS = 32,
  parameter int unsigned AW     = 8,
  parameter int unsigned DW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [AW-1:0]     bus_addr,
  input logic              bus_we,
  input logic [DW-1:0]     bus_wdata,
  input logic [N_PINS-1:0] pin_oe,
  input logic              irq,
  input logic [N_PINS-1:0] sts_q,
  input logic [N_PINS-1:0] out_q,
  input logic [N_PINS-1:0] irq_en
);

  AST_SET_ORS_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_SET)) |=>
      ((out_q & $past(bus_wdata[N_PINS-1:0])) == $past(bus_wdata[N_PINS-1:0]))); // R4

  AST_CLR_REMOVES: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_CLR)) |=>
      ((out_q & $past(bus_wdata[N_PINS-1:0])) == '0)); // R4

  AST_ALL_CFG_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(OFS_ALL)) |=>
      (pin_oe == {N_PINS{$past(bus_wdata[2])}})); // R3

  AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(OFS_STS)) |=>
      ((sts_q & $past(sts_q)) == $past(sts_q))); // R11

  AST_STS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q) & ~$past(irq_en)) == '0)); // R8

  AST_IRQ_FALL_ON_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(bus_we && bus_addr == AW'(OFS_STS))); // R10

endmodule

bind pio_ctrl pio_ctrl_chk #(.N_PINS(N_PINS), .AW(AW), .DW(DW)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .sts_q     (sts_q),
  .out_q     (out_q),
  .irq_en    (irq_en)
);

// File: tb/test_pio_ctrl.sv
`timescale 1ns/100ps
module test_pio_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'hFC;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_i = '0;
  logic [31:0] pin_o;
  logic [31:0] pin_oe;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pio_ctrl i_pio_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 8'hFC;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic irq_clean();
    wr(8'h8C, 32'h02);
    pin_i = '0;
    cyc(4);
    wr(8'h80, 32'hFFFF_FFFF);
  endtask

  task automatic t_reset();
    rd_chk("R1 cfg0", 8'h00, 0);
    rd_chk("R1 cfg31", 8'h7C, 0);
    rd_chk("R1 out", 8'h88, 0);
    rd_chk("R1 sts", 8'h80, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 pin_oe", pin_oe, 0);
    chk("R1 pin_o", pin_o, 0);
  endtask

  task automatic t_output();
    wr(8'h0C, 32'h05);
    rd_chk("R2 cfg3", 8'h0C, 32'h05);
    chk("R2 oe", pin_oe, 32'h08);
    wr(8'hA4, 32'h18);
    rd_chk("R4 set", 8'h88, 32'h18);
    chk("R2 pin_o gated", pin_o, 32'h08);
    wr(8'hA0, 32'h08);
    rd_chk("R4 clr", 8'h88, 32'h10);
    chk("R2 pin_o after clr", pin_o, 0);
    wr(8'h88, 32'hFFFF_0000);
    rd_chk("R4 direct", 8'h88, 32'hFFFF_0000);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R2 reserved bits", 8'h0C, 32'hEF);
  endtask

  task automatic t_groups();
    wr(8'h8C, 32'h02);
    rd_chk("R3 all pin0", 8'h00, 32'h02);
    rd_chk("R3 all pin31", 8'h7C, 32'h02);
    chk("R3 all oe", pin_oe, 0);
    wr(8'h98, 32'h05);
    rd_chk("R3 grp pin16", 8'h40, 32'h05);
    rd_chk("R3 grp pin23", 8'h5C, 32'h05);
    rd_chk("R3 grp pin15", 8'h3C, 32'h02);
    rd_chk("R3 grp pin24", 8'h60, 32'h02);
    chk("R3 grp oe", pin_oe, 32'h00FF_0000);
  endtask

  task automatic t_input();
    wr(8'h8C, 32'h02);
    @(negedge clk);
    pin_i = 32'hA5A5_0F0F;
    cyc(3);
    bus_addr = 8'h84;
    #1 chk("R5 in", bus_rdata, 32'hA5A5_0F0F);
    wr(8'h84, 32'h0);
    rd_chk("R5 in write ignored", 8'h84, 32'hA5A5_0F0F);
    wr(8'h00, 32'h05);
    rd_chk("R5 in gated", 8'h84, 32'hA5A5_0F0E);
  endtask

  task automatic t_rise();
    irq_clean();
    wr(8'h10, 32'h4A);
    pin_i[4] = 1'b1; cyc(4);
    rd_chk("R7 rise", 8'h80, 32'h10);
    chk("R10 irq", {31'd0, irq}, 1);
    pin_i[4] = 1'b0; cyc(4);
    rd_chk("R11 sticky", 8'h80, 32'h10);
    wr(8'h80, 32'h10);
    rd_chk("R9 clr", 8'h80, 0);
    chk("R10 irq low", {31'd0, irq}, 0);
    pin_i[4] = 1'b1; cyc(4);
    wr(8'h80, 32'h10);
    rd_chk("R9 edge stays clear", 8'h80, 0);
  endtask

  task automatic t_fall_both();
    irq_clean();
    wr(8'h14, 32'h6A);
    pin_i[5] = 1'b1; cyc(4);
    rd_chk("R7 fall ignores rise", 8'h80, 0);
    pin_i[5] = 1'b0; cyc(4);
    rd_chk("R7 fall", 8'h80, 32'h20);
    irq_clean();
    wr(8'h18, 32'h8A);
    pin_i[6] = 1'b1; cyc(4);
    rd_chk("R7 both rise", 8'h80, 32'h40);
    wr(8'h80, 32'hFFFF_FFFF);
    pin_i[6] = 1'b0; cyc(4);
    rd_chk("R7 both fall", 8'h80, 32'h40);
  endtask

  task automatic t_level();
    irq_clean();
    wr(8'h1C, 32'h0A);
    pin_i[7] = 1'b1; cyc(4);
    rd_chk("R6 level high", 8'h80, 32'h80);
    wr(8'h80, 32'h80);
    rd_chk("R9 level reasserts", 8'h80, 32'h80);
    pin_i[7] = 1'b0; cyc(4);
    wr(8'h80, 32'h80);
    rd_chk("R6 level high gone", 8'h80, 0);
    irq_clean();
    wr(8'h20, 32'h2A);
    cyc(2);
    rd_chk("R6 level low", 8'h80, 32'h100);
    pin_i[8] = 1'b1; cyc(4);
    wr(8'h80, 32'h100);
    rd_chk("R6 level low gone", 8'h80, 0);
  endtask

  task automatic t_disabled();
    irq_clean();
    wr(8'h24, 32'h42);
    pin_i[9] = 1'b1; cyc(4);
    rd_chk("R8 disabled", 8'h80, 0);
    chk("R8 irq quiet", {31'd0, irq}, 0);
    wr(8'h28, 32'hAA);
    pin_i[10] = 1'b1; cyc(4);
    pin_i[10] = 1'b0; cyc(4);
    rd_chk("R7 reserved code", 8'h80, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    irq_clean();
    wr(8'h10, 32'h4A);
    wr(8'h18, 32'h4A);
    pin_i[4] = 1'b1; pin_i[6] = 1'b1; cyc(4);
    rd(8'h80, v);
    chk("R9 two pending", v, 32'h50);
    wr(8'h80, 32'h10);
    rd(8'h80, v);
    chk("R9 partial clr", v, 32'h40);
    chk("R10 irq still", {31'd0, irq}, 1);
    wr(8'h80, v);
    rd_chk("R9 write back", 8'h80, 0);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(3);
    t_reset();
    t_output();
    t_groups();
    t_input();
    t_rise();
    t_fall_both();
    t_level();
    t_disabled();
    t_w1c();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule